// File: doc/BRIEF.md
# Display Memory Host Address Controller

This block sits between a host-side command decoder and a display memory that is organised as pages of eight pixel rows by columns of one byte each. There are eight full pages and a ninth icon page that is only one row high, and each page has 132 columns. The decoder hands the block one-cycle strobes for the address commands, for modify-read entry and exit, and for a soft reset. The host side hands it data-write and data-read strobes with one shared data byte. The block turns all of this into a registered RAM address, a write enable, a read enable and masked write data. It also returns a read-back byte through a holding register.

The column counter steps after every data access and does not depend on the page. Once it runs off the last existing column it locks, and it stays locked until software loads a new column. Reads are one access deep: a read strobe returns the byte that the previous read fetched. After any address change, the first read is therefore a dummy. Modify-read mode lets the host read and then rewrite a run of bytes. In this mode reads do not step the column. On exit, the column returns to where it stood at entry.

The host issues at most one strobe per cycle and leaves at least one idle cycle between two data accesses. The RAM is a synchronous memory that returns read data one clock after its read enable.

Top module: `pixmem_addr_ctrl`

## Requirements
- R1: The page register takes host_din[3:0] on cmd_page. Only pages 0 to 8 reach the RAM. For pages 9 to 15, a write raises no ram_we and is dropped, and a read raises no ram_re and fetches 0x00.
- R2: Page 8 is the icon page. A write there drives ram_wdata = {7'b0, host_din[0]}. A fetch from it delivers zeros in bits 7:1.
- R3: cmd_col_hi loads column bits 6:4 from host_din[2:0] and clears bit 7. cmd_col_lo loads column bits 3:0 from host_din[3:0]. Each leaves the other bits unchanged. Each data write, and each data read outside modify-read mode, advances the column by one and leaves the page unchanged.
- R4: When the column is 132 (0x84) or above, it does not advance and no RAM access is made. Loading a column with cmd_col_hi or cmd_col_lo releases the lock.
- R5: A valid write strobe drives ram_we high for exactly the following cycle. In that cycle ram_page and ram_col hold the page and column in force at the strobe. ram_we and ram_re are never high together.
- R6: On a read strobe, host_rdata takes, at that clock edge, the byte fetched by the previous read strobe. The first read after reset returns 0x00.
- R7: cmd_rmw_on records the column and enters modify-read mode. In that mode reads leave the column unchanged and writes still advance it. cmd_rmw_off restores the recorded column and leaves the mode. Outside the mode, cmd_rmw_off has no effect.
- R8: cmd_reset clears the page and the column to 0 and ends modify-read mode. It leaves RAM contents unchanged.
- R9: After rst, ram_we and ram_re are low and host_rdata is 0x00. Page and column are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_page | input | 1 | Load page from host_din[3:0] |
| cmd_col_hi | input | 1 | Load column bits 6:4 from host_din[2:0] |
| cmd_col_lo | input | 1 | Load column bits 3:0 from host_din[3:0] |
| cmd_rmw_on | input | 1 | Enter modify-read mode, record column |
| cmd_rmw_off | input | 1 | Leave modify-read mode, restore column |
| cmd_reset | input | 1 | Soft reset of page, column and mode |
| host_wr | input | 1 | Data write strobe |
| host_rd | input | 1 | Data read strobe |
| host_din | input | 8 | Command argument or write data |
| ram_page | output | 4 | RAM page address |
| ram_col | output | 8 | RAM column address |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_re |
| host_rdata | output | 8 | Read-back byte from the holding register |

## Verification
Some properties hold on every cycle and are checked by assertions. These are: RAM enables appear only for existing pages and columns, icon writes are masked, the column stays frozen while locked and during reads in modify-read mode, exit from the mode restores the recorded column, and invalid or icon fetches fill the holder with zeros in the right bits. Other behaviour depends on sequences of operations, so only the bench's scenarios against its reference model can show it. This covers the one-deep read latency and its dummy first read, the run of writes across the last valid column into the lock, release of the lock by a column load, and RAM contents surviving a soft reset.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_DATA_W    = 8;
  localparam int PM_PAGE_W    = 4;
  localparam int PM_COL_W     = 8;
  localparam int PM_NUM_COLS  = 132;
  localparam int PM_ICON_PAGE = 8;
  localparam int PM_COL_LO_W  = 4;

  // one-hot command strobes from the decoder
  typedef struct packed {
    logic soft_rst;
    logic rmw_off;
    logic rmw_on;
    logic col_hi;
    logic col_lo;
    logic page;
  } pm_cmd_t;
endpackage

// File: rtl/pm_page_reg.sv
module pm_page_reg #(
  parameter int PAGE_W    = pm_pkg::PM_PAGE_W,
  parameter int ICON_PAGE = pm_pkg::PM_ICON_PAGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              set_page,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_ok,
  output logic              page_icon
);
  localparam logic [PAGE_W-1:0] ICON_C = PAGE_W'(ICON_PAGE);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) page_q <= '0;
    else if (set_page)   page_q <= din;
  end

  assign page_ok   = (page_q <= ICON_C);
  assign page_icon = (page_q == ICON_C);

  AST_PAGE_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> page_q == '0); // R8
endmodule

// File: rtl/pm_col_ctr.sv
module pm_col_ctr #(
  parameter int COL_W    = pm_pkg::PM_COL_W,
  parameter int NUM_COLS = pm_pkg::PM_NUM_COLS,
  parameter int LO_W     = pm_pkg::PM_COL_LO_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  set_hi,
  input  logic                  set_lo,
  input  logic                  rmw_on,
  input  logic                  rmw_off,
  input  logic [COL_W-LO_W-2:0] din_hi,
  input  logic [LO_W-1:0]       din_lo,
  input  logic                  acc_wr,
  input  logic                  acc_rd,
  output logic [COL_W-1:0]      col_q,
  output logic                  col_ok,
  output logic                  rmw_q
);
  localparam int HI_W = COL_W - LO_W - 1;
  localparam logic [COL_W-1:0] LIMIT_C = COL_W'(NUM_COLS);

  logic [COL_W-1:0] saved_q;
  logic             step;

  assign col_ok = (col_q < LIMIT_C);
  assign step   = col_ok && (acc_wr || (acc_rd && !rmw_q));

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      col_q   <= '0;
      saved_q <= '0;
      rmw_q   <= 1'b0;
    end else if (set_hi) begin
      col_q[COL_W-1]              <= 1'b0;
      col_q[LO_W+HI_W-1:LO_W]     <= din_hi;
    end else if (set_lo) begin
      col_q[LO_W-1:0] <= din_lo;
    end else if (rmw_on) begin
      saved_q <= col_q;
      rmw_q   <= 1'b1;
    end else if (rmw_off) begin
      if (rmw_q) col_q <= saved_q;
      rmw_q <= 1'b0;
    end else if (step) begin
      col_q <= col_q + 1'b1;
    end
  end

  AST_COL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!col_ok && !set_hi && !set_lo && !rmw_off && !soft_rst) |=> $stable(col_q)); // R4
  AST_RMW_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rmw_q && acc_rd && !set_hi && !set_lo && !rmw_on && !rmw_off && !soft_rst)
      |=> $stable(col_q)); // R7
  AST_RMW_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (rmw_q && rmw_off && !set_hi && !set_lo && !rmw_on && !soft_rst)
      |=> col_q == $past(saved_q)); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (col_q == '0 && !rmw_q)); // R8
endmodule

// File: rtl/pm_bus_holder.sv
module pm_bus_holder #(
  parameter int DATA_W = pm_pkg::PM_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_ok,
  input  logic              launch_icon,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rd_byte
);
  // stage 1: RAM sees its read enable; stage 2: RAM data is valid
  logic              pend1, ok1, icon1;
  logic              pend2, ok2, icon2;
  logic [DATA_W-1:0] holder_q;
  logic [DATA_W-1:0] fetched;

  always_comb begin
    if (!ok2)       fetched = '0;
    else if (icon2) fetched = {{(DATA_W-1){1'b0}}, ram_rdata[0]};
    else            fetched = ram_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend1 <= 1'b0; ok1 <= 1'b0; icon1 <= 1'b0;
      pend2 <= 1'b0; ok2 <= 1'b0; icon2 <= 1'b0;
    end else begin
      pend1 <= launch; ok1 <= launch_ok; icon1 <= launch_icon;
      pend2 <= pend1;  ok2 <= ok1;       icon2 <= icon1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holder_q <= '0;
      rd_byte  <= '0;
    end else begin
      if (pend2)  holder_q <= fetched;
      if (launch) rd_byte  <= pend2 ? fetched : holder_q;
    end
  end

  AST_HOLD_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pend2 && !ok2) |=> holder_q == '0); // R1
  AST_HOLD_ICON_MASK: assert property (@(posedge clk) disable iff (rst)
    (pend2 && icon2) |=> holder_q[DATA_W-1:1] == '0); // R2
  AST_RDBYTE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !launch |=> $stable(rd_byte)); // R6
endmodule

// File: rtl/pixmem_addr_ctrl.sv
module pixmem_addr_ctrl #(
  parameter int DATA_W    = pm_pkg::PM_DATA_W,
  parameter int PAGE_W    = pm_pkg::PM_PAGE_W,
  parameter int COL_W     = pm_pkg::PM_COL_W,
  parameter int NUM_COLS  = pm_pkg::PM_NUM_COLS,
  parameter int ICON_PAGE = pm_pkg::PM_ICON_PAGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_page,
  input  logic              cmd_col_hi,
  input  logic              cmd_col_lo,
  input  logic              cmd_rmw_on,
  input  logic              cmd_rmw_off,
  input  logic              cmd_reset,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_din,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_col,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] host_rdata
);
  import pm_pkg::*;
  localparam int LO_W = PM_COL_LO_W;
  localparam int HI_W = COL_W - LO_W - 1;

  pm_cmd_t          cmd;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              page_ok, page_icon, col_ok, rmw_q, acc_ok;
  logic [DATA_W-1:0] wdata_m;

  assign cmd = '{soft_rst: cmd_reset, rmw_off: cmd_rmw_off, rmw_on: cmd_rmw_on,
                 col_hi: cmd_col_hi, col_lo: cmd_col_lo, page: cmd_page};

  pm_page_reg #(.PAGE_W(PAGE_W), .ICON_PAGE(ICON_PAGE)) u_page (
    .clk(clk), .rst(rst), .soft_rst(cmd.soft_rst), .set_page(cmd.page),
    .din(host_din[PAGE_W-1:0]), .page_q(page_q), .page_ok(page_ok),
    .page_icon(page_icon));

  pm_col_ctr #(.COL_W(COL_W), .NUM_COLS(NUM_COLS), .LO_W(LO_W)) u_col (
    .clk(clk), .rst(rst), .soft_rst(cmd.soft_rst), .set_hi(cmd.col_hi),
    .set_lo(cmd.col_lo), .rmw_on(cmd.rmw_on), .rmw_off(cmd.rmw_off),
    .din_hi(host_din[HI_W-1:0]), .din_lo(host_din[LO_W-1:0]),
    .acc_wr(host_wr), .acc_rd(host_rd), .col_q(col_q), .col_ok(col_ok),
    .rmw_q(rmw_q));

  assign acc_ok  = page_ok && col_ok;
  assign wdata_m = page_icon ? {{(DATA_W-1){1'b0}}, host_din[0]} : host_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_page  <= '0;
      ram_col   <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= host_wr && acc_ok;
      ram_re <= host_rd && acc_ok;
      if ((host_wr || host_rd) && acc_ok) begin
        ram_page <= page_q;
        ram_col  <= col_q;
      end
      if (host_wr) ram_wdata <= wdata_m;
    end
  end

  pm_bus_holder #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .launch(host_rd), .launch_ok(acc_ok),
    .launch_icon(page_icon), .ram_rdata(ram_rdata), .rd_byte(host_rdata));

  AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> (ram_page <= PAGE_W'(ICON_PAGE) &&
                            ram_col < COL_W'(NUM_COLS))); // R1
  AST_ICON_WRITE_MASK: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_page == PAGE_W'(ICON_PAGE)) |-> ram_wdata[DATA_W-1:1] == '0); // R2
  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re)); // R5
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !host_wr) |=> !ram_we); // R5
  AST_RMW_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(rmw_q) |-> $past(cmd_rmw_on)); // R7
endmodule

// File: tb/test_pixmem_addr_ctrl.sv
module test_pixmem_addr_ctrl;
  localparam int COLS = 132;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       cmd_page = 0, cmd_col_hi = 0, cmd_col_lo = 0;
  logic       cmd_rmw_on = 0, cmd_rmw_off = 0, cmd_reset = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [7:0] host_din = '0;
  logic [3:0] ram_page;
  logic [7:0] ram_col, ram_wdata, host_rdata;
  logic [7:0] ram_rdata = '0;
  logic       ram_we, ram_re;

  pixmem_addr_ctrl i_pixmem_addr_ctrl (
    .clk(clk), .rst(rst), .cmd_page(cmd_page), .cmd_col_hi(cmd_col_hi),
    .cmd_col_lo(cmd_col_lo), .cmd_rmw_on(cmd_rmw_on), .cmd_rmw_off(cmd_rmw_off),
    .cmd_reset(cmd_reset), .host_wr(host_wr), .host_rd(host_rd),
    .host_din(host_din), .ram_page(ram_page), .ram_col(ram_col),
    .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .host_rdata(host_rdata));

  // behavioural RAM: 9 pages x 132 columns
  logic [7:0] ram_m [0:9*COLS-1];
  initial for (int i = 0; i < 9*COLS; i++) ram_m[i] = '0;
  always @(posedge clk) begin
    if (ram_we) ram_m[int'(ram_page)*COLS + int'(ram_col)] <= ram_wdata;
    if (ram_re) ram_rdata <= ram_m[int'(ram_page)*COLS + int'(ram_col)];
  end

  int checks = 0, errors = 0;

  // reference model
  logic [7:0] ref_m [0:9*COLS-1];
  initial for (int i = 0; i < 9*COLS; i++) ref_m[i] = '0;
  int pg_m = 0, col_m = 0, save_m = 0;
  bit rmw_m = 0;
  logic [7:0] hold_m = '0;

  // scoreboard
  logic [7:0] exp_q[$];
  string      req_q[$];

  initial begin
    forever begin
      @(posedge clk);
      if (host_rd === 1'b1 && rst === 1'b0) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R6 unexpected read result actual=%02h expected=none", host_rdata);
        end else begin
          logic [7:0] e; string r;
          e = exp_q.pop_front(); r = req_q.pop_front();
          checks++;
          if (host_rdata !== e) begin
            errors++;
            $display("FAIL %s read byte actual=%02h expected=%02h", r, host_rdata, e);
          end
        end
      end
    end
  end

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit ok_m();
    return (pg_m <= 8) && (col_m < COLS);
  endfunction

  task automatic cmd(string kind, logic [7:0] d);
    @(negedge clk);
    host_din = d;
    case (kind)
      "page":   cmd_page = 1;
      "hi":     cmd_col_hi = 1;
      "lo":     cmd_col_lo = 1;
      "rmwon":  cmd_rmw_on = 1;
      "rmwoff": cmd_rmw_off = 1;
      default:  cmd_reset = 1;
    endcase
    @(negedge clk);
    {cmd_page, cmd_col_hi, cmd_col_lo, cmd_rmw_on, cmd_rmw_off, cmd_reset} = '0;
    case (kind)
      "page":   pg_m = int'(d[3:0]);
      "hi":     col_m = (int'(d[2:0]) << 4) | (col_m & 15);
      "lo":     col_m = (col_m & 'hF0) | int'(d[3:0]);
      "rmwon":  begin save_m = col_m; rmw_m = 1; end
      "rmwoff": begin if (rmw_m) col_m = save_m; rmw_m = 0; end
      default:  begin pg_m = 0; col_m = 0; rmw_m = 0; end
    endcase
  endtask

  task automatic set_addr(int p, int c);
    cmd("page", 8'(p));
    cmd("hi", 8'(c >> 4));
    cmd("lo", 8'(c & 15));
  endtask

  task automatic wr(logic [7:0] d, string req);
    bit ok; logic [7:0] md;
    ok = ok_m();
    md = (pg_m == 8) ? {7'b0, d[0]} : d;
    @(negedge clk);
    host_din = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    if (ok)
      check(ram_we === 1'b1 && ram_page == 4'(pg_m) && ram_col == 8'(col_m) &&
            ram_wdata == md, req, "write page/col/data",
            {ram_we, ram_page, ram_col, ram_wdata}, {1'b1, 4'(pg_m), 8'(col_m), md});
    else
      check(ram_we === 1'b0, req, "dropped write we", int'(ram_we), 0);
    if (ok) ref_m[pg_m*COLS + col_m] = md;
    if (col_m < COLS) col_m++;
    @(negedge clk);
  endtask

  task automatic rd(string req);
    bit ok;
    ok = ok_m();
    exp_q.push_back(hold_m); req_q.push_back(req);
    @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    check(ram_re === ok, req, "read enable", int'(ram_re), int'(ok));
    hold_m = ok ? ((pg_m == 8) ? {7'b0, ref_m[pg_m*COLS + col_m][0]}
                               : ref_m[pg_m*COLS + col_m]) : 8'h00;
    if (!rmw_m && col_m < COLS) col_m++;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(ram_we === 0 && ram_re === 0, "R9", "enables after reset", {ram_we, ram_re}, 0);
    check(host_rdata === 8'h00, "R9", "host_rdata after reset", host_rdata, 0);
    // R9 address 0 seen on first write; R5 address timing
    wr(8'hA5, "R9");
    wr(8'h3C, "R5");
    // R3 column loads and increment, page untouched
    set_addr(3, 'h10);
    for (int i = 0; i < 5; i++) wr(8'(8'h11 * (i + 1)), "R3");
    cmd("hi", 8'hFD);                 // bits 6:4 <- 5, upper din bits ignored
    wr(8'h77, "R3");
    // R6 dummy read then sequential reads
    set_addr(3, 'h10);
    for (int i = 0; i < 6; i++) rd("R6");
    // R4 lock near top column
    set_addr(1, 'h7E);
    for (int i = 0; i < 8; i++) wr(8'(8'hC0 + i), "R4");
    rd("R4");
    cmd("lo", 8'h02);                 // column becomes 0x82: unlocked
    wr(8'h5A, "R4");
    set_addr(1, 'h7F);
    for (int i = 0; i < 7; i++) rd("R4");
    // R2 icon page
    set_addr(8, 'h20);
    wr(8'hFF, "R2"); wr(8'hFE, "R2"); wr(8'h81, "R2");
    set_addr(8, 'h20);
    for (int i = 0; i < 4; i++) rd("R2");
    // R1 pages beyond icon page
    set_addr(9, 'h05);
    wr(8'h99, "R1");
    rd("R1"); rd("R1");
    cmd("page", 8'h0F);
    wr(8'h42, "R1"); rd("R1");
    // R7 modify-read
    set_addr(2, 'h05);
    wr(8'h10, "R7"); wr(8'h20, "R7");
    set_addr(2, 'h05);
    cmd("rmwon", 8'h00);
    rd("R7"); rd("R7");
    wr(8'h1F, "R7");
    rd("R7"); rd("R7");
    wr(8'h2F, "R7");
    cmd("rmwoff", 8'h00);
    wr(8'hE5, "R7");                  // back at column 5
    cmd("rmwoff", 8'h00);             // no effect outside mode
    wr(8'hE6, "R7");
    set_addr(2, 'h05);
    rd("R7"); rd("R7"); rd("R7");
    // R8 soft reset
    set_addr(4, 'h30);
    cmd("rmwon", 8'h00);
    cmd("reset", 8'h00);
    wr(8'hD8, "R8");                  // page 0 column 0
    rd("R8"); rd("R8");               // not in modify-read: column advances
    set_addr(3, 'h10);
    rd("R8"); rd("R8"); rd("R8");     // earlier data still in RAM
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6", "pending reads", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule